// File: doc/BRIEF.md
# ATA Channel Probe and Reset Sequencer

This block discovers which of the two drive positions on a parallel ATA channel hold a device. After a start pulse it drives the channel's register bus. It selects the master and then the slave, and after each selection it reads that position's status byte. A position is screened out when its status reads all ones, which is a pulled-up empty bus, or when it returns the exact byte just written, which is an un-terminated bus echoing the last value.

If no position survives the screen, the block finishes at once with a fail result and never touches the control register. Otherwise it performs a software reset through the device control register. It then polls the busy bit of both positions, with a fixed gap between polls, until the expected drives are idle or an iteration limit runs out. Any position still busy at the limit is dropped. The outcome is a two-bit presence mask with a done and a fail flag, which stay valid until the next start.

Every bus access is a one-cycle strobe followed by a fixed latency, after which read data is taken. The settle, reset-hold and poll-gap delays and the iteration limit are parameters.

Top module: `ata_probe_seq`

## Requirements
- R1: After reset, busy_o, done_o, fail_o, bus_stb_o and mask_o are all zero.
- R2: After start, the first four bus accesses are: a write of 0xA0 to register select 0x6 (drive/head), a read of register 0x7 (status), a write of 0xB0 (bit 4 set, slave) to 0x6, and another read of 0x7. Each strobe lasts exactly one cycle.
- R3: A position is marked absent when its status byte is 0xFF, or when it equals the drive/head byte written just before it (0xA0 for the master, 0xB0 for the slave).
- R4: When both positions are absent, the block sets done_o and fail_o with mask_o = 0 and makes no write to register 0xE (device control).
- R5: When at least one position survives, the next accesses are: write 0xA0 to 0x6, write 0x06 to 0xE (reset bit 2 plus interrupt-disable bit 1), write 0x02 to 0xE, read register 0x1 (error) and discard it, then write 0x08 to 0xE. The gap between the first two control writes is at least RST_HOLD_CYC cycles.
- R6: Each poll iteration writes 0xA0 to 0x6, reads 0x7, writes 0xB0 to 0x6 and reads 0x7. The iterations are separated by a POLL_GAP_CYC wait, and there are at most POLL_LIMIT of them.
- R7: Polling ends successfully, with the screened mask unchanged, at the first iteration in which every expected position has status bit 7 (busy) clear. A position that was screened out is ignored.
- R8: If the limit is reached, mask bit 0 is cleared when the master's last status had bit 7 set, and bit 1 likewise for the slave. fail_o is set exactly when the resulting mask is zero.
- R9: done_o, fail_o and mask_o hold until the next accepted start. A start while busy_o is high is ignored. Accepting a start clears done_o and raises busy_o on the following cycle.
- R10: mask_o bit 0 stands for the master (drive 0) and bit 1 for the slave (drive 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a probe (ignored while busy) |
| bus_stb_o | output | 1 | One-cycle access strobe |
| bus_we_o | output | 1 | Access is a write |
| bus_addr_o | output | 4 | Register select, held until the next access |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data, sampled BUS_LAT cycles after the strobe |
| busy_o | output | 1 | Probe in progress |
| done_o | output | 1 | Result valid |
| fail_o | output | 1 | No drive found |
| mask_o | output | 2 | Presence mask, bit 0 master, bit 1 slave |

## Verification
A wrong sequencer state shows up on the bus straight away. An access is skipped, repeated or misordered, or a control write appears after an empty screen, and the bench's per-access log catches this at the strobe where the trace departs from the expected pattern. A wrong screen or completion decision changes the number of poll iterations and the final mask, and both are compared when done_o rises. A stale iteration count or a mask bit dropped at the wrong time is visible as a wrong access count or mask within the same probe.

// File: rtl/ata_probe_pkg.sv
package ata_probe_pkg;
  localparam logic [3:0] REG_ERR  = 4'h1;
  localparam logic [3:0] REG_DH   = 4'h6;
  localparam logic [3:0] REG_STAT = 4'h7;
  localparam logic [3:0] REG_CTL  = 4'hE;

  localparam logic [7:0] DH_MASTER = 8'hA0;
  localparam logic [7:0] DH_SLAVE  = 8'hB0;
  localparam logic [7:0] CTL_SRST  = 8'h04;
  localparam logic [7:0] CTL_NIEN  = 8'h02;
  localparam logic [7:0] CTL_FINAL = 8'h08;
  localparam int         BSY_BIT   = 7;

  typedef enum logic [4:0] {
    S_IDLE, S_SC_SEL0, S_SC_SET0, S_SC_RD0, S_SC_SEL1, S_SC_SET1, S_SC_RD1,
    S_SC_EVAL, S_RS_SEL, S_RS_SET, S_RS_ON, S_RS_HOLD, S_RS_OFF, S_RS_REC,
    S_RS_ERR, S_RS_FIN, S_RS_SET2, S_PL_SEL0, S_PL_SET0, S_PL_RD0, S_PL_SEL1,
    S_PL_SET1, S_PL_RD1, S_PL_EVAL, S_PL_GAP
  } step_e;

  typedef enum logic [1:0] {ACT_NONE, ACT_WR, ACT_RD, ACT_WAIT} act_e;
  typedef enum logic [1:0] {DLY_SETTLE, DLY_HOLD, DLY_GAP} dly_e;
  typedef enum logic {PH_GO, PH_RUN} phase_e;
endpackage

// File: rtl/ata_bus_port.sv
module ata_bus_port #(
  parameter int BUS_LAT = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       we_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic       bus_stb_o,
  output logic       bus_we_o,
  output logic [3:0] bus_addr_o,
  output logic [7:0] bus_wdata_o,
  input  logic [7:0] bus_rdata_i,
  output logic [7:0] rdata_o,
  output logic       done_o
);
  localparam int CW = $clog2(BUS_LAT + 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      cnt_q       <= '0;
      bus_stb_o   <= 1'b0;
      bus_we_o    <= 1'b0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
      rdata_o     <= '0;
      done_o      <= 1'b0;
    end else begin
      bus_stb_o <= 1'b0;
      done_o    <= 1'b0;
      if (start_i && !active_q) begin
        active_q    <= 1'b1;
        cnt_q       <= CW'(BUS_LAT);
        bus_stb_o   <= 1'b1;
        bus_we_o    <= we_i;
        bus_addr_o  <= addr_i;
        bus_wdata_o <= wdata_i;
      end else if (active_q) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          active_q <= 1'b0;
          rdata_o  <= bus_rdata_i;
          done_o   <= 1'b1;
        end
      end
    end
  end

  a_r2_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_stb_o |=> !bus_stb_o);

  a_r2_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !bus_stb_o) |-> $stable(bus_addr_o));
endmodule

// File: rtl/ata_delay_timer.sv
module ata_delay_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] count_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_i) begin
        cnt_q <= count_i;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == W'(1)) done_o <= 1'b1;
      end
    end
  end

  a_r5_no_reload_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (cnt_q == '0));
endmodule

// File: rtl/ata_probe_eval.sv
module ata_probe_eval
  import ata_probe_pkg::*;
(
  input  logic [1:0]      mask_i,
  input  logic [1:0][7:0] stat_i,
  input  logic [1:0][7:0] dh_i,
  output logic [1:0]      scr_mask_o,
  output logic            poll_done_o,
  output logic [1:0]      drop_mask_o
);
  logic [1:0] bsy;

  for (genvar d = 0; d < 2; d++) begin : g_drv
    assign scr_mask_o[d] = !((stat_i[d] == 8'hFF) || (stat_i[d] == dh_i[d]));
    assign bsy[d]        = stat_i[d][BSY_BIT];
  end

  always_comb begin
    unique case (mask_i)
      2'b01:   poll_done_o = !bsy[0];
      2'b10:   poll_done_o = !bsy[1];
      2'b11:   poll_done_o = !bsy[0] && !bsy[1];
      default: poll_done_o = 1'b1;
    endcase
  end

  assign drop_mask_o = mask_i & ~bsy;
endmodule

// File: rtl/ata_probe_seq.sv
module ata_probe_seq
  import ata_probe_pkg::*;
#(
  parameter int BUS_LAT      = 2,
  parameter int SETTLE_CYC   = 4,
  parameter int RST_HOLD_CYC = 1000,
  parameter int POLL_GAP_CYC = 100,
  parameter int POLL_LIMIT   = 31000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output logic       bus_stb_o,
  output logic       bus_we_o,
  output logic [3:0] bus_addr_o,
  output logic [7:0] bus_wdata_o,
  input  logic [7:0] bus_rdata_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       fail_o,
  output logic [1:0] mask_o
);
  localparam int DLY_MAX = (RST_HOLD_CYC > POLL_GAP_CYC) ?
                           ((RST_HOLD_CYC > SETTLE_CYC) ? RST_HOLD_CYC : SETTLE_CYC) :
                           ((POLL_GAP_CYC > SETTLE_CYC) ? POLL_GAP_CYC : SETTLE_CYC);
  localparam int DW = $clog2(DLY_MAX + 1);
  localparam int IW = $clog2(POLL_LIMIT + 1);

  step_e      st_q;
  phase_e     ph_q;
  logic [1:0] mask_q;
  logic       done_q, fail_q;
  logic [7:0] st0_q, st1_q;
  logic [IW-1:0] iter_q;

  act_e       act;
  logic [3:0] act_addr;
  logic [7:0] act_data;
  dly_e       act_dly;
  logic [DW-1:0] dly_cnt;

  logic       bus_start, bus_done, tmr_load, tmr_done, step_done;
  logic [7:0] rdata;
  logic [1:0] scr_mask, drop_mask;
  logic       poll_done;

  always_comb begin
    act      = ACT_NONE;
    act_addr = REG_DH;
    act_data = 8'h00;
    act_dly  = DLY_SETTLE;
    unique case (st_q)
      S_SC_SEL0, S_RS_SEL, S_PL_SEL0: begin act = ACT_WR; act_data = DH_MASTER; end
      S_SC_SEL1, S_PL_SEL1:           begin act = ACT_WR; act_data = DH_SLAVE; end
      S_SC_SET0, S_SC_SET1, S_RS_SET, S_RS_SET2, S_PL_SET0, S_PL_SET1:
        act = ACT_WAIT;
      S_SC_RD0, S_SC_RD1, S_PL_RD0, S_PL_RD1: begin act = ACT_RD; act_addr = REG_STAT; end
      S_RS_ON:  begin act = ACT_WR; act_addr = REG_CTL; act_data = CTL_SRST | CTL_NIEN; end
      S_RS_HOLD, S_RS_REC: begin act = ACT_WAIT; act_dly = DLY_HOLD; end
      S_RS_OFF: begin act = ACT_WR; act_addr = REG_CTL; act_data = CTL_NIEN; end
      S_RS_ERR: begin act = ACT_RD; act_addr = REG_ERR; end
      S_RS_FIN: begin act = ACT_WR; act_addr = REG_CTL; act_data = CTL_FINAL; end
      S_PL_GAP: begin act = ACT_WAIT; act_dly = DLY_GAP; end
      default:  act = ACT_NONE;
    endcase
  end

  always_comb begin
    unique case (act_dly)
      DLY_HOLD: dly_cnt = DW'(RST_HOLD_CYC);
      DLY_GAP:  dly_cnt = DW'(POLL_GAP_CYC);
      default:  dly_cnt = DW'(SETTLE_CYC);
    endcase
  end

  function automatic step_e succ(step_e s);
    unique case (s)
      S_SC_SEL0: return S_SC_SET0;
      S_SC_SET0: return S_SC_RD0;
      S_SC_RD0:  return S_SC_SEL1;
      S_SC_SEL1: return S_SC_SET1;
      S_SC_SET1: return S_SC_RD1;
      S_SC_RD1:  return S_SC_EVAL;
      S_RS_SEL:  return S_RS_SET;
      S_RS_SET:  return S_RS_ON;
      S_RS_ON:   return S_RS_HOLD;
      S_RS_HOLD: return S_RS_OFF;
      S_RS_OFF:  return S_RS_REC;
      S_RS_REC:  return S_RS_ERR;
      S_RS_ERR:  return S_RS_FIN;
      S_RS_FIN:  return S_RS_SET2;
      S_RS_SET2: return S_PL_SEL0;
      S_PL_SEL0: return S_PL_SET0;
      S_PL_SET0: return S_PL_RD0;
      S_PL_RD0:  return S_PL_SEL1;
      S_PL_SEL1: return S_PL_SET1;
      S_PL_SET1: return S_PL_RD1;
      S_PL_RD1:  return S_PL_EVAL;
      S_PL_GAP:  return S_PL_SEL0;
      default:   return S_IDLE;
    endcase
  endfunction

  assign bus_start = (ph_q == PH_GO) && ((act == ACT_WR) || (act == ACT_RD));
  assign tmr_load  = (ph_q == PH_GO) && (act == ACT_WAIT);
  assign step_done = bus_done || tmr_done;

  ata_bus_port #(.BUS_LAT(BUS_LAT)) u_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (bus_start),
    .we_i       (act == ACT_WR),
    .addr_i     (act_addr),
    .wdata_i    (act_data),
    .bus_stb_o  (bus_stb_o),
    .bus_we_o   (bus_we_o),
    .bus_addr_o (bus_addr_o),
    .bus_wdata_o(bus_wdata_o),
    .bus_rdata_i(bus_rdata_i),
    .rdata_o    (rdata),
    .done_o     (bus_done)
  );

  ata_delay_timer #(.W(DW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .count_i(dly_cnt),
    .done_o (tmr_done)
  );

  ata_probe_eval u_eval (
    .mask_i     (mask_q),
    .stat_i     ({st1_q, st0_q}),
    .dh_i       ({DH_SLAVE, DH_MASTER}),
    .scr_mask_o (scr_mask),
    .poll_done_o(poll_done),
    .drop_mask_o(drop_mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      ph_q   <= PH_GO;
      mask_q <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      st0_q  <= '0;
      st1_q  <= '0;
      iter_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (start_i) begin
            st_q   <= S_SC_SEL0;
            ph_q   <= PH_GO;
            mask_q <= 2'b11;
            done_q <= 1'b0;
            fail_q <= 1'b0;
            iter_q <= '0;
          end
        end
        S_SC_EVAL: begin
          mask_q <= scr_mask;
          if (scr_mask == 2'b00) begin
            done_q <= 1'b1;
            fail_q <= 1'b1;
            st_q   <= S_IDLE;
          end else begin
            st_q <= S_RS_SEL;
          end
        end
        S_PL_EVAL: begin
          if (poll_done) begin
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end else if (iter_q == IW'(POLL_LIMIT - 1)) begin
            mask_q <= drop_mask;
            fail_q <= (drop_mask == 2'b00);
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end else begin
            iter_q <= iter_q + 1'b1;
            st_q   <= S_PL_GAP;
          end
        end
        default: begin
          if (ph_q == PH_GO) begin
            ph_q <= PH_RUN;
          end else if (step_done) begin
            ph_q <= PH_GO;
            st_q <= succ(st_q);
            if (st_q == S_SC_RD0 || st_q == S_PL_RD0) st0_q <= rdata;
            if (st_q == S_SC_RD1 || st_q == S_PL_RD1) st1_q <= rdata;
          end
        end
      endcase
    end
  end

  assign busy_o = (st_q != S_IDLE);
  assign done_o = done_q;
  assign fail_o = fail_q;
  assign mask_o = mask_q;

  a_r4_no_ctl_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_stb_o && bus_we_o && (bus_addr_o == REG_CTL)) |-> (mask_q != 2'b00));

  a_r8_mask_only_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) |-> ((mask_o & ~$past(mask_o)) == 2'b00));

  a_r8_fail_iff_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (fail_o == (mask_o == 2'b00)));

  a_r9_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));

  a_r9_result_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(mask_o) && $stable(fail_o)));

  a_r6_iter_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_q < IW'(POLL_LIMIT));

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !bus_stb_o);
endmodule

// File: tb/tb_ata_probe_seq.sv
module tb_ata_probe_seq;
  localparam int BUS_LAT = 2;
  localparam int SETTLE  = 3;
  localparam int HOLD    = 20;
  localparam int GAP     = 4;
  localparam int LIMIT   = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       stb, we;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       busy, done, fail;
  logic [1:0] mask;

  always #10 clk = ~clk;

  ata_probe_seq #(
    .BUS_LAT(BUS_LAT), .SETTLE_CYC(SETTLE), .RST_HOLD_CYC(HOLD),
    .POLL_GAP_CYC(GAP), .POLL_LIMIT(LIMIT)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .bus_stb_o(stb), .bus_we_o(we), .bus_addr_o(addr), .bus_wdata_o(wdata),
    .bus_rdata_i(rdata), .busy_o(busy), .done_o(done), .fail_o(fail), .mask_o(mask)
  );

  // drive model configuration (bench-owned)
  logic [1:0] cfg_pres = 2'b00;
  logic [1:0] cfg_echo = 2'b00;
  int         cfg_busy [2];
  logic       mdl_clr = 1'b0;

  // model state (model-owned)
  logic       m_sel;
  logic       m_armed;
  logic [7:0] m_last;
  int         m_selcnt [2];
  int         op_n;
  int         cyc;
  logic [3:0] op_addr [64];
  logic       op_we   [64];
  logic [7:0] op_data [64];
  int         op_cyc  [64];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mdl_clr) begin
      m_sel <= 1'b0; m_armed <= 1'b0; m_last <= 8'h00;
      m_selcnt[0] <= 0; m_selcnt[1] <= 0; op_n <= 0;
    end else if (stb) begin
      if (op_n < 64) begin
        op_addr[op_n] <= addr; op_we[op_n] <= we;
        op_data[op_n] <= wdata; op_cyc[op_n] <= cyc;
      end
      op_n <= op_n + 1;
      if (we) begin
        m_last <= wdata;
        if (addr == 4'h6) begin
          m_sel <= wdata[4];
          if (m_armed) m_selcnt[wdata[4]] <= m_selcnt[wdata[4]] + 1;
        end
        if (addr == 4'hE && wdata[2]) begin
          m_armed <= 1'b1; m_selcnt[0] <= 0; m_selcnt[1] <= 0;
        end
      end
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (addr == 4'h7) begin
      if (!cfg_pres[m_sel])      rdata = cfg_echo[m_sel] ? m_last : 8'hFF;
      else if (m_armed && (m_selcnt[m_sel] <= cfg_busy[m_sel])) rdata = 8'h80;
      else                       rdata = 8'h50;
    end else if (addr == 4'h1) begin
      rdata = 8'h01;
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_op(string tag, int i, logic w, logic [3:0] a, logic [7:0] d);
    chk({tag, " we"}, int'(op_we[i]), int'(w));
    chk({tag, " addr"}, int'(op_addr[i]), int'(a));
    if (w) chk({tag, " data"}, int'(op_data[i]), int'(d));
  endtask

  task automatic finish_all();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // expected result from the requirements
  task automatic expect_res(input logic [1:0] p, input int b0, input int b1,
                            output logic [1:0] em, output int iters);
    logic bz0, bz1, fin;
    em = p; iters = 0; fin = 1'b0;
    if (p == 2'b00) return;
    for (int k = 0; k < LIMIT && !fin; k++) begin
      bz0 = !p[0] || (k < b0);
      bz1 = !p[1] || (k < b1);
      iters = k + 1;
      if ((p == 2'b01 && !bz0) || (p == 2'b10 && !bz1) || (p == 2'b11 && !bz0 && !bz1))
        fin = 1'b1;
      else if (k == LIMIT - 1)
        em = p & ~{bz1, bz0};
    end
  endtask

  task automatic run_case(string name, logic [1:0] p, logic [1:0] echo,
                          int b0, int b1, bit poke);
    logic [1:0] em;
    int iters, base, w;
    logic [7:0] dh;
    expect_res(p, b0, b1, em, iters);
    @(negedge clk); #2;
    cfg_pres = p; cfg_echo = echo; cfg_busy[0] = b0; cfg_busy[1] = b1;
    mdl_clr = 1'b1;
    @(negedge clk); #2;
    mdl_clr = 1'b0;
    start = 1'b1;
    @(negedge clk); #2;
    start = 1'b0;
    chk({name, " R9 busy after start"}, int'(busy), 1);
    chk({name, " R9 done cleared"}, int'(done), 0);
    w = 0;
    while (!done) begin
      @(negedge clk);
      w++;
      if (poke && w == 40) begin
        #2 start = 1'b1;
        @(negedge clk); #2 start = 1'b0;
      end
      if (w > 5000) begin
        errors++;
        $display("FAIL watchdog %s actual 0 expected 1", name);
        finish_all();
      end
    end
    chk({name, " R10 mask"}, int'(mask), int'(em));
    chk({name, " R8 fail"}, int'(fail), int'(em == 2'b00));
    chk_op({name, " R2 op0"}, 0, 1'b1, 4'h6, 8'hA0);
    chk_op({name, " R2 op1"}, 1, 1'b0, 4'h7, 8'h00);
    chk_op({name, " R2 op2"}, 2, 1'b1, 4'h6, 8'hB0);
    chk_op({name, " R2 op3"}, 3, 1'b0, 4'h7, 8'h00);
    if (p == 2'b00) begin
      chk({name, " R4 no reset accesses"}, op_n, 4);
    end else begin
      chk_op({name, " R5 sel"}, 4, 1'b1, 4'h6, 8'hA0);
      chk_op({name, " R5 srst"}, 5, 1'b1, 4'hE, 8'h06);
      chk_op({name, " R5 release"}, 6, 1'b1, 4'hE, 8'h02);
      chk_op({name, " R5 err read"}, 7, 1'b0, 4'h1, 8'h00);
      chk_op({name, " R5 final"}, 8, 1'b1, 4'hE, 8'h08);
      chk({name, " R5 hold"}, int'(op_cyc[6] - op_cyc[5] >= HOLD), 1);
      chk({name, " R6 access count"}, op_n, 9 + 4 * iters);
      for (int i = 9; i < op_n && i < 64; i++) begin
        base = (i - 9) % 4;
        dh = (base == 0) ? 8'hA0 : 8'hB0;
        if (base == 0 || base == 2) chk_op({name, " R6 poll sel"}, i, 1'b1, 4'h6, dh);
        else                        chk_op({name, " R6 poll rd"}, i, 1'b0, 4'h7, 8'h00);
      end
    end
    repeat (5) @(negedge clk);
    chk({name, " R9 done held"}, int'(done), 1);
    chk({name, " R9 mask held"}, int'(mask), int'(em));
  endtask

  initial begin
    cfg_busy[0] = 0; cfg_busy[1] = 0;
    void'($urandom(32'h5EED));
    mdl_clr = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 fail", int'(fail), 0);
    chk("R1 mask", int'(mask), 0);
    chk("R1 strobe", int'(stb), 0);
    rst_n = 1'b1;
    mdl_clr = 1'b0;

    run_case("R7 master only", 2'b01, 2'b00, 2, 0, 0);
    run_case("R7 slave only echo", 2'b10, 2'b01, 0, 3, 0);
    run_case("R7 both present", 2'b11, 2'b00, 1, 4, 0);
    run_case("R4 empty float", 2'b00, 2'b00, 0, 0, 0);
    run_case("R3 empty echo", 2'b00, 2'b11, 0, 0, 0);
    run_case("R3 mixed absent", 2'b00, 2'b10, 0, 0, 0);
    run_case("R8 master stuck", 2'b11, 2'b00, 999, 1, 0);
    run_case("R8 both stuck", 2'b11, 2'b00, 999, 999, 0);
    run_case("R8 limit edge", 2'b01, 2'b00, LIMIT - 1, 0, 0);
    run_case("R8 just over", 2'b10, 2'b00, 0, LIMIT, 0);
    run_case("R9 start while busy", 2'b11, 2'b00, 2, 2, 1);

    for (int n = 0; n < 24; n++) begin
      logic [1:0] p, e;
      int b0, b1;
      p  = 2'($urandom_range(3));
      e  = 2'($urandom_range(3));
      b0 = $urandom_range(LIMIT + 2);
      b1 = $urandom_range(LIMIT + 2);
      run_case("R7 random", p, e, b0, b1, 0);
    end
    finish_all();
  end
endmodule